// File: doc/BRIEF.md
# Dual-Rail Handshake Register Stage

This block is one storage stage of a self-timed pipeline that carries words in dual-rail form. Every bit travels on two wires: the "one" rail high with the "zero" rail low means logic 1, the reverse means logic 0, and both low is the empty spacer that means no value yet. The stage lets alternating DATA and spacer wavefronts through from its input to its output. It only does so when the stage that follows asks for them with its request line.

Each output rail holds its value. A rail sets when its input rail is high and the downstream request asks for DATA. It clears when its input rail is low and the request asks for a spacer. In all other cases it keeps its value. A completion detector looks at the whole output word and drives the acknowledge back to the previous stage. The acknowledge is high (ready for DATA) once every output bit is empty. It is low (ready for spacer) once every output bit holds DATA. This makes an empty wavefront separate any two DATA words. One DATA-to-DATA round trip of the handshake takes the place of a clock period.

The model is cycle based. The rails are registers on a common clock with a synchronous active-high reset. The acknowledge is formed combinationally from the registered rails and its own held state.

Top module: `ncl_reg_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, every output rail is 0 and `ko` is 1 (ready for DATA).
- R2: Bit encoding: `r1=1,r0=0` is logic 1, `r1=0,r0=1` is logic 0, both 0 is empty. With `ki=1`, a valid DATA input bit shows at the output after one clock edge.
- R3: With `ki=0`, a DATA word at the input does not reach an empty output. The output stays all 0.
- R4: An output rail clears only on an edge where `ki=0` and its input rail is low. An empty input with `ki=1` leaves held DATA unchanged. With `ki=0`, bits whose input is still DATA keep their value.
- R5: An output bit that holds DATA is never replaced by a different DATA value. It must first return to empty.
- R6: An input bit with both rails high is never latched, and no output bit ever has both rails high.
- R7: `ko` goes to 0 in the same cycle that every output bit holds DATA. While only some bits hold DATA it stays 1.
- R8: `ko` returns to 1 only when every output bit is empty. While only some bits are empty it stays 0.
- R9: Under a request/acknowledge exchange with random delays on both sides, the output delivers the input words in order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state-holding rails |
| rst | input | 1 | Synchronous active-high reset |
| din_r0 | input | W | Zero rails of the incoming dual-rail word |
| din_r1 | input | W | One rails of the incoming dual-rail word |
| ki | input | 1 | Request from the next stage: 1 asks for DATA, 0 asks for spacer |
| dout_r0 | output | W | Zero rails of the held word |
| dout_r1 | output | W | One rails of the held word |
| ko | output | 1 | Acknowledge to the previous stage: 1 ready for DATA, 0 ready for spacer |

## Verification
A wrong rail would show up at the ports one clock edge after the stimulus that disturbed it. It could appear as a bit that shows DATA while the request asks for a spacer, as a DATA bit that flips value without passing through empty, or as a bit with both rails high. A wrong completion state would show at once as `ko` changing while the output word is only partly full or partly empty. In the random handshake run, such an error would stall the exchange or make the scoreboard see a word lost, repeated or out of order.

// File: rtl/ncl_pkg.sv
package ncl_pkg;

    // One dual-rail bit: r1 carries logic 1, r0 carries logic 0.
    typedef struct packed {
        logic r1;
        logic r0;
    } dr_bit_t;

    // Downstream request encoding.
    typedef enum logic {
        REQ_SPACER = 1'b0,
        REQ_DATA   = 1'b1
    } req_e;

    localparam dr_bit_t DR_EMPTY = '{r1: 1'b0, r0: 1'b0};

    function automatic logic dr_is_data(input dr_bit_t b);
        return b.r1 ^ b.r0;
    endfunction

    function automatic logic dr_is_empty(input dr_bit_t b);
        return ~(b.r1 | b.r0);
    endfunction

endpackage

// File: rtl/ncl_dr_cell.sv
module ncl_dr_cell
    import ncl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  req_e    req,
    input  dr_bit_t d,
    output dr_bit_t q
);

    logic set_one, set_zero, clr_one, clr_zero;

    // A rail sets only for a valid DATA input bit and only while the other
    // output rail is low, so a held DATA value cannot be overwritten.
    always_comb begin
        set_one  = (req == REQ_DATA) & d.r1 & ~d.r0 & ~q.r0;
        set_zero = (req == REQ_DATA) & d.r0 & ~d.r1 & ~q.r1;
        clr_one  = (req == REQ_SPACER) & ~d.r1;
        clr_zero = (req == REQ_SPACER) & ~d.r0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= DR_EMPTY;
        end else begin
            if (set_one)       q.r1 <= 1'b1;
            else if (clr_one)  q.r1 <= 1'b0;
            if (set_zero)      q.r0 <= 1'b1;
            else if (clr_zero) q.r0 <= 1'b0;
        end
    end

endmodule

// File: rtl/ncl_completion.sv
module ncl_completion
    import ncl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] q_r0,
    input  logic [W-1:0] q_r1,
    output logic         ko
);

    logic [W-1:0] bit_data;
    logic [W-1:0] bit_empty;
    logic         word_data;
    logic         word_empty;
    logic         ko_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        dr_bit_t b;
        assign b            = '{r1: q_r1[i], r0: q_r0[i]};
        assign bit_data[i]  = dr_is_data(b);
        assign bit_empty[i] = dr_is_empty(b);
    end

    assign word_data  = &bit_data;
    assign word_empty = &bit_empty;

    // Hysteresis: switch only on a complete word, otherwise keep the last state.
    always_comb begin
        if (word_empty)     ko = 1'b1;
        else if (word_data) ko = 1'b0;
        else                ko = ko_q;
    end

    always_ff @(posedge clk) begin
        if (rst) ko_q <= 1'b1;
        else     ko_q <= ko;
    end

endmodule

// File: rtl/ncl_reg_stage.sv
module ncl_reg_stage
    import ncl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din_r0,
    input  logic [W-1:0] din_r1,
    input  logic         ki,
    output logic [W-1:0] dout_r0,
    output logic [W-1:0] dout_r1,
    output logic         ko
);

    req_e req;
    assign req = ki ? REQ_DATA : REQ_SPACER;

    for (genvar i = 0; i < W; i++) begin : g_cell
        dr_bit_t d_bit;
        dr_bit_t q_bit;
        assign d_bit = '{r1: din_r1[i], r0: din_r0[i]};
        ncl_dr_cell u_cell (
            .clk (clk),
            .rst (rst),
            .req (req),
            .d   (d_bit),
            .q   (q_bit)
        );
        assign dout_r1[i] = q_bit.r1;
        assign dout_r0[i] = q_bit.r0;
    end

    ncl_completion #(.W(W)) u_done (
        .clk  (clk),
        .rst  (rst),
        .q_r0 (dout_r0),
        .q_r1 (dout_r1),
        .ko   (ko)
    );

endmodule

// File: rtl/ncl_reg_stage_chk.sv
module ncl_reg_stage_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         ki,
    input logic [W-1:0] dout_r0,
    input logic [W-1:0] dout_r1,
    input logic         ko
);

    logic all_data, all_empty;
    assign all_data  = &(dout_r0 ^ dout_r1);
    assign all_empty = ~|(dout_r0 | dout_r1);

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (all_empty && ko));

    // R6
    no_illegal_out_chk: assert property (@(posedge clk) disable iff (rst)
        ~|(dout_r0 & dout_r1));

    // R3
    spacer_req_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (!ki && all_empty) |=> all_empty);

    // R5
    no_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (ki && all_data) |=> ($stable(dout_r0) && $stable(dout_r1)));

    // R7
    ko_fall_full_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ko) |-> all_data);

    // R8
    ko_rise_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ko) |-> all_empty);

endmodule

bind ncl_reg_stage ncl_reg_stage_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .ki      (ki),
    .dout_r0 (dout_r0),
    .dout_r1 (dout_r1),
    .ko      (ko)
);

// File: tb/ncl_reg_stage_tb.sv
module ncl_reg_stage_tb;

    localparam int W      = 8;
    localparam int NWORDS = 200;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din_r0 = '0;
    logic [W-1:0] din_r1 = '0;
    logic         ki = 1'b0;
    logic [W-1:0] dout_r0;
    logic [W-1:0] dout_r1;
    logic         ko;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_q[$];

    always #5 clk = ~clk;

    ncl_reg_stage #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .din_r0(din_r0), .din_r1(din_r1),
        .ki(ki), .dout_r0(dout_r0), .dout_r1(dout_r1), .ko(ko)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [W-1:0] w);
        din_r1 = w;
        din_r0 = ~w;
    endtask

    task automatic put_empty();
        din_r1 = '0;
        din_r0 = '0;
    endtask

    function automatic logic out_full();
        return &(dout_r0 ^ dout_r1);
    endfunction

    function automatic logic out_empty();
        return ~|(dout_r0 | dout_r1);
    endfunction

    // R6: output rails must never both be high
    always @(negedge clk) begin
        if (!rst && |(dout_r0 & dout_r1)) begin
            fails++;
            $display("FAIL R6: illegal output r1=%h r0=%h expected no bit with both rails", dout_r1, dout_r0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic driver();
        for (int n = 0; n < NWORDS; n++) begin
            logic [W-1:0] w;
            while (!ko) @(negedge clk);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            w = W'($urandom);
            exp_q.push_back(w);
            put_word(w);
            @(negedge clk);
            while (ko) @(negedge clk);
            repeat ($urandom_range(0, 3)) @(negedge clk);
            put_empty();
            @(negedge clk);
        end
    endtask

    task automatic consumer();
        int got = 0;
        while (got < NWORDS) begin
            @(negedge clk);
            if (ki && out_full()) begin
                logic [W-1:0] w;
                logic [W-1:0] e;
                w = dout_r1;
                e = (exp_q.size() > 0) ? exp_q.pop_front() : ~w;
                check("R9 word order", w, e);
                repeat ($urandom_range(0, 3)) begin
                    @(negedge clk);
                    // R5: held word unchanged while next stage still asks for DATA
                    if (dout_r1 !== w || dout_r0 !== ~w) begin
                        fails++;
                        $display("FAIL R5: actual %h expected %h", dout_r1, w);
                    end
                end
                ki = 1'b0;
                got++;
            end else if (!ki && out_empty()) begin
                repeat ($urandom_range(0, 3)) @(negedge clk);
                ki = 1'b1;
            end
        end
        while (!out_empty()) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rails", {dout_r1, dout_r0}, '0);
        check("R1 ko", ko, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {dout_r1, dout_r0, 7'd0, ko}, 32'h1);

        // R3: DATA with spacer request stays out
        ki = 1'b0;
        put_word(8'hA5);
        repeat (3) @(negedge clk);
        check("R3 rails", {dout_r1, dout_r0}, '0);
        check("R3 ko", ko, 1);

        // R2 / R7: request DATA, one edge later word visible and ko low
        ki = 1'b1;
        @(negedge clk);
        check("R2 r1", dout_r1, 8'hA5);
        check("R2 r0", dout_r0, 8'h5A);
        check("R7 ko full", ko, 0);

        // R5: new DATA without spacer is not taken
        put_word(8'h3C);
        repeat (2) @(negedge clk);
        check("R5 no overwrite", {dout_r1, dout_r0}, {8'hA5, 8'h5A});

        // R4: empty input with DATA request holds
        put_empty();
        repeat (2) @(negedge clk);
        check("R4 hold", {dout_r1, dout_r0}, {8'hA5, 8'h5A});

        // R8: partial spacer keeps ko low
        ki = 1'b0;
        din_r1 = 8'hA0;
        din_r0 = 8'h50;
        @(negedge clk);
        check("R4 partial clear", {dout_r1, dout_r0}, {8'hA0, 8'h50});
        check("R8 ko partial", ko, 0);
        put_empty();
        @(negedge clk);
        check("R8 empty", {dout_r1, dout_r0, 7'd0, ko}, 32'h1);

        // R7: partial DATA keeps ko high
        ki = 1'b1;
        din_r1 = 8'h03;
        din_r0 = 8'h0C;
        @(negedge clk);
        check("R7 partial rails", {dout_r1, dout_r0}, {8'h03, 8'h0C});
        check("R7 ko partial", ko, 1);
        put_word(8'h93);
        @(negedge clk);
        check("R7 full rails", {dout_r1, dout_r0}, {8'h93, 8'h6C});
        check("R7 ko full", ko, 0);
        ki = 1'b0;
        put_empty();
        @(negedge clk);
        check("R8 return", ko, 1);

        // R6: illegal bit 0 not latched
        ki = 1'b1;
        din_r1 = 8'hFF;
        din_r0 = 8'h01;
        @(negedge clk);
        check("R6 illegal bit", {dout_r1, dout_r0}, {8'hFE, 8'h00});
        check("R6 ko", ko, 1);
        ki = 1'b0;
        put_empty();
        @(negedge clk);
        check("R6 cleared", {dout_r1, dout_r0, 7'd0, ko}, 32'h1);

        // R9: random handshake scoreboard
        ki = 1'b1;
        fork
            driver();
            consumer();
        join
        check("R9 queue drained", exp_q.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule